// File: doc/BRIEF.md
# Signal Level Meter for Gain Control

This block measures how strong a complex baseband stream is, so that a gain control loop can act on it. Each qualified sample pair (I, Q) is turned into its instantaneous power. A coarse right shift scales that power down, and the scaled value then goes into a first-order integrate-and-dump accumulator that closes a partial sum every M accepted samples. A short history of earlier partial sums is kept. Each time a partial sum closes, the newest N partial sums are added together, which gives a window of N·M samples that moves forward by M samples per result.

The window sum is converted to a fixed-point base-2 logarithm. The integer part is the position of the leading one, and the four fraction bits come from a sixteen-entry mantissa correction. The log value is then halved, which takes the square root in the log domain. Each result is one log-RMS word with a one-cycle valid strobe. The gain loop that uses the word lies outside this block. The decimation ratio, the averaging multiple and the attenuation shift are static configuration inputs. A change of the ratio or the multiple restarts the measurement.

Top module: `agc_level_meter`

## Requirements
- R1: On every cycle with `smp_valid` high, the signed two's-complement pair `smp_i`, `smp_q` contributes the power I·I + Q·Q. Cycles with `smp_valid` low contribute nothing, whatever the data inputs hold.
- R2: The decimation ratio is M = `dec_sel` + 1 (1 to 4096). One result is produced for every M accepted samples once the window is full, and at no other time.
- R3: The averaging multiple is N = `avg_sel` + 1 (1 to 4). Each result covers the sum of the attenuated powers of the last N·M accepted samples.
- R4: Each power is shifted right, with truncation, by `att_shift` before it is accumulated. A setting of 15 acts as 14.
- R5: The log value of a window sum X > 0 is L = 16·E + F. E is the index of the most significant set bit of X. F = round(16·log2(1 + m/16)), where m is the 4-bit field just below that leading one, padded with zeros on the right when fewer than four bits exist below it.
- R6: `lvl_rms` equals L shifted right by one bit.
- R7: A window sum of zero gives `lvl_rms` = 0.
- R8: After reset, and after any change of `dec_sel` or `avg_sel`, the accumulator and partial-sum history are cleared. The first result then follows only after N complete decimation periods.
- R9: A result whose last sample is captured on clock edge k is presented with `lvl_valid` high during the cycle that follows edge k+2.
- R10: During and immediately after reset, `lvl_valid` and `lvl_rms` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies the sample pair |
| smp_i | input | IN_W | In-phase sample, signed |
| smp_q | input | IN_W | Quadrature sample, signed |
| dec_sel | input | M_W | Decimation ratio minus one |
| avg_sel | input | N_W | Averaging multiple minus one |
| att_shift | input | S_W | Pre-accumulation right shift |
| lvl_valid | output | 1 | One-cycle strobe for a new result |
| lvl_rms | output | LOG_W | Log2 RMS level, four fraction bits |

## Verification
A result is due exactly three negative clock edges after the negative edge that drove its last valid sample: one register stage holds the power, one the window sum and one the log word. For every window completion the bench model records the cycle number at which the result must appear. A monitor on the falling edge compares both the value and the cycle of each strobe with the oldest pending entry, and it reports any strobe that arrives when nothing is pending. Configuration changes are made only after the pipeline has drained, so each pending result belongs to a single configuration.

// File: rtl/lvlm_pkg.sv
package lvlm_pkg;

  localparam int FRAC_W = 4;

  // round(16 * log2(1 + m/16)) for the four mantissa bits below the leading one
  function automatic logic [FRAC_W-1:0] frac_lut(input logic [FRAC_W-1:0] m);
    logic [FRAC_W-1:0] f;
    case (m)
      4'd0:  f = 4'd0;
      4'd1:  f = 4'd1;
      4'd2:  f = 4'd3;
      4'd3:  f = 4'd4;
      4'd4:  f = 4'd5;
      4'd5:  f = 4'd6;
      4'd6:  f = 4'd7;
      4'd7:  f = 4'd8;
      4'd8:  f = 4'd9;
      4'd9:  f = 4'd10;
      4'd10: f = 4'd11;
      4'd11: f = 4'd12;
      4'd12: f = 4'd13;
      4'd13: f = 4'd14;
      4'd14: f = 4'd15;
      default: f = 4'd15;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/lvlm_power.sv
module lvlm_power #(
  parameter int IN_W    = 16,
  parameter int S_W     = 4,
  parameter int ATT_MAX = 14,
  localparam int P_W    = 2*IN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_v,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  input  logic [S_W-1:0]         shift,
  output logic                   out_v,
  output logic [P_W-1:0]         out_p
);

  function automatic logic [P_W-1:0] inst_pow(input logic signed [IN_W-1:0] a,
                                               input logic signed [IN_W-1:0] b);
    logic signed [P_W-1:0] ea, eb;
    ea = P_W'(a);
    eb = P_W'(b);
    return $unsigned(ea*ea) + $unsigned(eb*eb);
  endfunction

  function automatic logic [S_W-1:0] eff_shift(input logic [S_W-1:0] s);
    return (s > S_W'(ATT_MAX)) ? S_W'(ATT_MAX) : s;
  endfunction

  logic [P_W-1:0] raw_pow;
  logic [S_W-1:0] sh_eff;

  assign raw_pow = inst_pow(in_i, in_q);
  assign sh_eff  = eff_shift(shift);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_p <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_p <= raw_pow >> sh_eff;
    end
  end

  AST_IDLE_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    !in_v |=> !out_v); // R1
  AST_POWER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> out_p <= (P_W'(1) << (P_W-1))); // R1

endmodule

// File: rtl/lvlm_avg.sv
module lvlm_avg #(
  parameter int P_W    = 32,
  parameter int M_W    = 12,
  parameter int N_W    = 2,
  localparam int NMAX  = 1 << N_W,
  localparam int HIST  = NMAX - 1,
  localparam int ACC_W = P_W + M_W,
  localparam int SUM_W = ACC_W + N_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [P_W-1:0]   in_p,
  input  logic [M_W-1:0]   m_sel,
  input  logic [N_W-1:0]   n_sel,
  output logic             sum_v,
  output logic [SUM_W-1:0] sum_o
);

  logic [M_W-1:0]   m_q, cnt_q;
  logic [N_W-1:0]   n_q, fill_q;
  logic [ACC_W-1:0] acc_q, part;
  logic [ACC_W-1:0] hist_q [HIST];
  logic [ACC_W-1:0] term   [HIST];
  logic [SUM_W-1:0] win;
  logic             cfg_chg, dump, win_ok;

  assign cfg_chg = (m_sel != m_q) || (n_sel != n_q);
  assign dump    = in_v && !cfg_chg && (cnt_q == m_sel);
  assign part    = acc_q + ACC_W'(in_p);
  assign win_ok  = (fill_q >= n_sel);

  // select the older partial sums that belong to the current window
  for (genvar h = 0; h < HIST; h++) begin : g_term
    assign term[h] = (n_sel > N_W'(h)) ? hist_q[h] : '0;
  end

  always_comb begin
    win = SUM_W'(part);
    for (int h = 0; h < HIST; h++) win = win + SUM_W'(term[h]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q    <= '0;
      n_q    <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      fill_q <= '0;
      sum_v  <= 1'b0;
      sum_o  <= '0;
      for (int h = 0; h < HIST; h++) hist_q[h] <= '0;
    end else begin
      m_q   <= m_sel;
      n_q   <= n_sel;
      sum_v <= 1'b0;
      if (cfg_chg) begin
        cnt_q  <= '0;
        acc_q  <= '0;
        fill_q <= '0;
        for (int h = 0; h < HIST; h++) hist_q[h] <= '0;
      end else if (dump) begin
        cnt_q     <= '0;
        acc_q     <= '0;
        hist_q[0] <= part;
        for (int h = 1; h < HIST; h++) hist_q[h] <= hist_q[h-1];
        if (fill_q != N_W'(HIST)) fill_q <= fill_q + 1'b1;
        sum_v <= win_ok;
        sum_o <= win;
      end else if (in_v) begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= part;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= m_q); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_v && !cfg_chg && !dump |=> acc_q >= $past(acc_q)); // R3
  AST_CLEAR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !sum_v && acc_q == '0); // R8
  AST_RESULT_ON_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    sum_v |-> $past(in_v)); // R2

endmodule

// File: rtl/lvlm_log.sv
module lvlm_log #(
  parameter int SUM_W  = 46,
  localparam int FRAC_W = lvlm_pkg::FRAC_W,
  localparam int E_W    = $clog2(SUM_W),
  localparam int LOG_W  = E_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [SUM_W-1:0] in_sum,
  output logic             out_v,
  output logic [LOG_W-1:0] out_rms
);

  // fixed-point log2: leading-one index, then corrected mantissa fraction
  function automatic logic [LOG_W-1:0] log2_fx(input logic [SUM_W-1:0] x);
    int               e;
    logic [SUM_W-1:0] nrm;
    logic [FRAC_W-1:0] m;
    e = 0;
    for (int b = 0; b < SUM_W; b++) if (x[b]) e = b;
    nrm = x << (SUM_W - 1 - e);
    m   = nrm[SUM_W-2 -: FRAC_W];
    return {E_W'(e), lvlm_pkg::frac_lut(m)};
  endfunction

  logic [LOG_W-1:0] lpow;

  assign lpow = (in_sum == '0) ? '0 : log2_fx(in_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_rms <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_rms <= lpow >> 1;
    end
  end

  AST_ZERO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_v && in_sum == '0 |=> out_v && out_rms == '0); // R7
  AST_RMS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> out_rms[LOG_W-1] == 1'b0); // R6

endmodule

// File: rtl/agc_level_meter.sv
module agc_level_meter #(
  parameter int IN_W    = 16,
  parameter int M_W     = 12,
  parameter int N_W     = 2,
  parameter int S_W     = 4,
  parameter int ATT_MAX = 14,
  localparam int P_W    = 2*IN_W,
  localparam int SUM_W  = P_W + M_W + N_W,
  localparam int LOG_W  = $clog2(SUM_W) + lvlm_pkg::FRAC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic signed [IN_W-1:0] smp_i,
  input  logic signed [IN_W-1:0] smp_q,
  input  logic [M_W-1:0]         dec_sel,
  input  logic [N_W-1:0]         avg_sel,
  input  logic [S_W-1:0]         att_shift,
  output logic                   lvl_valid,
  output logic [LOG_W-1:0]       lvl_rms
);

  logic             pw_v, sum_v;
  logic [P_W-1:0]   pw;
  logic [SUM_W-1:0] sum_w;

  lvlm_power #(.IN_W(IN_W), .S_W(S_W), .ATT_MAX(ATT_MAX)) u_power (
    .clk(clk), .rst_n(rst_n), .in_v(smp_valid), .in_i(smp_i), .in_q(smp_q),
    .shift(att_shift), .out_v(pw_v), .out_p(pw)
  );

  lvlm_avg #(.P_W(P_W), .M_W(M_W), .N_W(N_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .in_v(pw_v), .in_p(pw), .m_sel(dec_sel),
    .n_sel(avg_sel), .sum_v(sum_v), .sum_o(sum_w)
  );

  lvlm_log #(.SUM_W(SUM_W)) u_log (
    .clk(clk), .rst_n(rst_n), .in_v(sum_v), .in_sum(sum_w),
    .out_v(lvl_valid), .out_rms(lvl_rms)
  );

  AST_OUT_AFTER_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> $past(sum_v)); // R9
  AST_OUT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sum_v |-> $past(pw_v)); // R9

endmodule

// File: tb/test_agc_level_meter.sv
module test_agc_level_meter;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_W = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [15:0] smp_i = '0, smp_q = '0;
  logic [11:0]        dec_sel = '0;
  logic [1:0]         avg_sel = '0;
  logic [3:0]         att_shift = '0;
  logic               lvl_valid;
  logic [LOG_W-1:0]   lvl_rms;

  agc_level_meter i_agc_level_meter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .dec_sel(dec_sel), .avg_sel(avg_sel), .att_shift(att_shift),
    .lvl_valid(lvl_valid), .lvl_rms(lvl_rms)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  cyc = 0;
  int  nchk = 0, nfail = 0;
  bit  done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { longint unsigned sum; int due; string tag; } exp_t;
  exp_t pend[$];

  // reference model state
  int M = 1, N = 1, S = 0, cnt_m = 0, fill_m = 0;
  longint unsigned acc_m = 0;
  longint unsigned hist_m [3];
  string cur_tag = "R3";

  task automatic chk(bit ok, string req, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_rms(longint unsigned s);
    int e; real r, f; int m;
    if (s == 0) return 0;
    e = 0;
    while ((s >> (e+1)) != 0) e++;
    r = real'(s) / (2.0 ** e);
    m = $rtoi((r - 1.0) * 16.0);
    f = $ln(1.0 + m / 16.0) / $ln(2.0) * 16.0;
    return (e*16 + $rtoi(f + 0.5)) >> 1;
  endfunction

  task automatic model_clear();
    acc_m = 0; cnt_m = 0; fill_m = 0;
    for (int h = 0; h < 3; h++) hist_m[h] = 0;
  endtask

  task automatic send(bit v, logic signed [15:0] si, logic signed [15:0] sq);
    longint unsigned p, part, win;
    exp_t e;
    @(negedge clk);
    smp_valid = v; smp_i = si; smp_q = sq;
    if (v) begin
      p = longint'(si)*longint'(si) + longint'(sq)*longint'(sq);
      p = p >> ((S > 14) ? 14 : S);
      part = acc_m + p;
      cnt_m++;
      if (cnt_m == M) begin
        win = part;
        for (int h = 0; h < N-1; h++) win += hist_m[h];
        if (fill_m >= N-1) begin
          e.sum = win; e.due = cyc + 3; e.tag = cur_tag;
          pend.push_back(e);
        end
        hist_m[2] = hist_m[1]; hist_m[1] = hist_m[0]; hist_m[0] = part;
        if (fill_m < 3) fill_m++;
        acc_m = 0; cnt_m = 0;
      end else begin
        acc_m = part;
      end
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) send(1'b0, 16'($urandom), 16'($urandom));
  endtask

  task automatic config_set(int m, int n, int s);
    idle(4);
    @(negedge clk);
    dec_sel = 12'(m-1); avg_sel = 2'(n-1); att_shift = 4'(s);
    M = m; N = n; S = s;
    model_clear();
    idle(2);
  endtask

  task automatic stream(int count, int gap_pct, int amp);
    int sent = 0;
    while (sent < count) begin
      if ($urandom_range(99) < gap_pct) send(1'b0, 16'($urandom), 16'($urandom));
      else begin
        send(1'b1, 16'($signed($urandom_range(2*amp)) - amp),
                   16'($signed($urandom_range(2*amp)) - amp));
        sent++;
      end
    end
  endtask

  task automatic drain(string req);
    idle(5);
    chk(pend.size() == 0, req, pend.size(), 0);
    pend.delete();
  endtask

  // monitor: value and arrival cycle against the oldest pending result
  always @(negedge clk) begin
    if (rst_n && lvl_valid) begin
      if (pend.size() == 0) chk(1'b0, "R2 unexpected result", lvl_rms, -1);
      else begin
        exp_t e;
        e = pend.pop_front();
        chk(cyc == e.due, "R9 arrival cycle", cyc, e.due);
        chk(lvl_rms == LOG_W'(exp_rms(e.sum)), e.tag, lvl_rms, exp_rms(e.sum));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A6C_0D35));
    model_clear();
    repeat (3) @(negedge clk);
    chk(lvl_valid == 1'b0, "R10 valid in reset", lvl_valid, 0);
    chk(lvl_rms == '0, "R10 level in reset", lvl_rms, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    chk(lvl_valid == 1'b0 && lvl_rms == '0, "R10 after reset", lvl_rms, 0);

    // per-sample results, full scale, zero and one
    config_set(1, 1, 0);
    cur_tag = "R5";
    send(1'b1, -16'sd32768, -16'sd32768);
    send(1'b1, 16'sd3, 16'sd4);
    send(1'b1, 16'sd1, 16'sd0);
    cur_tag = "R7";
    send(1'b1, 16'sd0, 16'sd0);
    cur_tag = "R6";
    stream(40, 30, 30000);
    drain("R2 count M=1");

    // invalid cycles carry garbage data
    config_set(3, 2, 2);
    cur_tag = "R1";
    stream(60, 60, 20000);
    drain("R1 gaps");

    // attenuation clamp: 15 behaves as 14
    config_set(2, 1, 15);
    cur_tag = "R4";
    stream(20, 10, 32767);
    drain("R4 clamp");

    // zero after attenuation: small powers shifted to nothing
    config_set(2, 2, 14);
    cur_tag = "R7";
    stream(12, 0, 20);
    drain("R7 shifted out");

    // decimation 1000, multiple 3, shift 12
    config_set(1000, 3, 12);
    cur_tag = "R3";
    stream(6000, 5, 32767);
    drain("R3 M=1000 N=3");

    // largest window
    config_set(4096, 4, 14);
    cur_tag = "R2";
    stream(24576, 0, 32767);
    drain("R2 M=4096 N=4");

    // reconfigure mid-window: old partials must be discarded
    config_set(5, 2, 1);
    cur_tag = "R8";
    stream(7, 0, 30000);
    config_set(3, 2, 1);
    stream(9, 0, 30000);
    drain("R8 restart");

    // random small configurations
    for (int k = 0; k < 6; k++) begin
      int mm, nn;
      mm = $urandom_range(1, 8);
      nn = $urandom_range(1, 4);
      config_set(mm, nn, $urandom_range(0, 15));
      cur_tag = "R3";
      stream(mm*(nn+4), 25, 32767);
      drain("R2 random cfg");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule